// File: doc/BRIEF.md
# Parallel Flash Programming Interface

This block is the device-side controller for a pin-driven programming mode of a small on-chip code store of 2^ADDR_W bytes (4096 by default). An external programmer drives a high-voltage-present flag, the reset pin, a program strobe, an address-step strobe, a 4-bit operation code and an 8-bit data bus. The block returns read data with its own output enable, and a ready/busy flag. All inputs are taken as synchronous to `clk_i`.

The block holds its own address counter. The counter is cleared by a rising edge on the reset pin and stepped by rising edges on the step strobe. Byte writes, lock-bit writes and whole-array erase each run for a fixed number of clocks, and ready/busy is low while they run. A byte write can only clear bits. While a byte write is in flight, reading its address returns the pending byte with bit 7 inverted, so the programmer can poll for completion. Two lock bits first stop further code writes and then also stop read-back. Only an erase clears them. A separate code returns two fixed identification bytes. The code store is a behavioural register array that starts fully erased after `rst_ni`.

Top module: `pgm_port_ctrl`

## Requirements
- R1: A rising edge on `rst_pin_i` (low in one sampled cycle, high in the next) sets the address counter to 0, whatever else is happening.
- R2: While ready, each rising edge on `step_i` adds one to the address counter. From address 2^ADDR_W-1 the counter wraps to 0.
- R3: A rising edge on `pgm_n_i` while ready, with `hv_i` high, `op_i` = 4'h2 and lock bit 1 clear, starts a byte write to the current address. The stored value becomes old byte AND `data_i`, so bits can only be cleared. The new value is visible once ready returns.
- R4: `rdy_o` drops in the cycle after the accepted strobe edge and stays low for exactly WR_CYC cycles for byte and lock writes.
- R5: While a byte write is in flight, a read of its address returns the pending byte with bit 7 inverted and bits 6..0 true.
- R6: With `op_i` = 4'h5 and `hv_i` high, holding `pgm_n_i` low for at least ERASE_HOLD sampled cycles and then releasing it sets every byte to FFh and clears both lock bits. Ready is low for 2^ADDR_W cycles. A shorter hold does nothing.
- R7: `op_i` = 4'h3 sets lock bit 1 and `op_i` = 4'h4 sets lock bit 2, each through a WR_CYC-cycle write. With lock bit 1 set, byte-write strobes are ignored: no busy period and no change to the data.
- R8: With both lock bits set, read mode (`op_i` = 4'h1) keeps `data_oe_o` low.
- R9: Identification mode (`op_i` = 4'h6) returns 1Eh at address 0, 41h at address 1 and 00h at other addresses, whatever the lock bits are.
- R10: `data_oe_o` is high only when `rst_pin_i` is high, `hv_i` is low and the op is a read that is not blocked or an identification read. When it is low, `data_o` is 00h.
- R11: Program and step strobes that arrive while busy are ignored.
- R12: Op codes 4'h0 and 4'h7..4'hF start nothing.
- R13: After `rst_ni`, every byte reads FFh, both lock bits are clear and `rdy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hv_i | input | 1 | High programming voltage present |
| rst_pin_i | input | 1 | Reset pin level |
| pgm_n_i | input | 1 | Program strobe, active low; acts on release |
| step_i | input | 1 | Address step strobe |
| op_i | input | 4 | Operation select |
| data_i | input | 8 | Data bus in |
| data_o | output | 8 | Data bus out |
| data_oe_o | output | 1 | Data bus output enable |
| rdy_o | output | 1 | High when ready, low when busy |

## Verification
The bench builds the block with ADDR_W = 3, WR_CYC = 5 and ERASE_HOLD = 6. With these values the address wrap takes only a few step pulses, a full erase sweep takes eight cycles, and the polling window of a byte write is short enough to probe each of its cycles. A behavioural reference model tracks the array, the lock bits and the busy periods and is compared with the outputs every cycle. Directed sequences add the short-hold erase, strobes during busy, and blocking by the lock bits.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  localparam logic [3:0] OP_READ  = 4'h1;
  localparam logic [3:0] OP_WRITE = 4'h2;
  localparam logic [3:0] OP_LOCK1 = 4'h3;
  localparam logic [3:0] OP_LOCK2 = 4'h4;
  localparam logic [3:0] OP_ERASE = 4'h5;
  localparam logic [3:0] OP_IDENT = 4'h6;

  localparam logic [7:0] IDENT_B0 = 8'h1E;
  localparam logic [7:0] IDENT_B1 = 8'h41;
  localparam logic [7:0] BLANK    = 8'hFF;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROG,
    ST_LOCK,
    ST_ERASE
  } pgm_state_e;
endpackage

// File: rtl/pgm_addr_ctr.sv
module pgm_addr_ctr #(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (clr_i)  addr_o <= '0;
    else if (step_i) addr_o <= addr_o + AW'(1);
  end
endmodule

// File: rtl/pgm_timer.sv
module pgm_timer #(
  parameter int CYC = 120000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= CW'(CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/pgm_hold_ctr.sv
module pgm_hold_ctr #(
  parameter int HOLD = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic ok_o
);
  localparam int HW = $clog2(HOLD + 1);
  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i)              cnt_q <= '0;
    else if (cnt_q != HW'(HOLD)) cnt_q <= cnt_q + HW'(1);
  end

  assign ok_o = (cnt_q == HW'(HOLD));
endmodule

// File: rtl/pgm_array.sv
module pgm_array #(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pgm_port_ctrl.sv
module pgm_port_ctrl
  import pgm_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int WR_CYC     = 120000,
  parameter int ERASE_HOLD = 1000000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hv_i,
  input  logic       rst_pin_i,
  input  logic       pgm_n_i,
  input  logic       step_i,
  input  logic [3:0] op_i,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  output logic       data_oe_o,
  output logic       rdy_o
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  pgm_state_e        state_q;
  logic              pgm_q, step_q, rstp_q;
  logic              lock1_q, lock2_q, lsel_q;
  logic [ADDR_W-1:0] addr, wr_addr_q, er_idx_q;
  logic [7:0]        wr_byte_q, rd_byte;
  logic              idle, pgm_rise, step_rise, rstp_rise;
  logic              start_wr, start_lk, start_er, tmr_done, hold_ok;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_waddr;
  logic [7:0]        arr_wdata;
  logic              rd_ok, poll;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pgm_q  <= 1'b1;
      step_q <= 1'b0;
      rstp_q <= 1'b0;
    end else begin
      pgm_q  <= pgm_n_i;
      step_q <= step_i;
      rstp_q <= rst_pin_i;
    end
  end

  assign idle      = (state_q == ST_IDLE);
  assign pgm_rise  = pgm_n_i & ~pgm_q;
  assign step_rise = step_i & ~step_q;
  assign rstp_rise = rst_pin_i & ~rstp_q;

  assign start_wr = idle & pgm_rise & hv_i & (op_i == OP_WRITE) & ~lock1_q;
  assign start_lk = idle & pgm_rise & hv_i & ((op_i == OP_LOCK1) | (op_i == OP_LOCK2));
  assign start_er = idle & pgm_rise & hv_i & (op_i == OP_ERASE) & hold_ok;

  pgm_addr_ctr #(.AW(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rstp_rise),
    .step_i (step_rise & idle),
    .addr_o (addr)
  );

  pgm_timer #(.CYC(WR_CYC)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_wr | start_lk),
    .done_o  (tmr_done)
  );

  pgm_hold_ctr #(.HOLD(ERASE_HOLD)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (~pgm_n_i & hv_i & (op_i == OP_ERASE)),
    .ok_o   (hold_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      lock1_q   <= 1'b0;
      lock2_q   <= 1'b0;
      lsel_q    <= 1'b0;
      wr_addr_q <= '0;
      wr_byte_q <= '0;
      er_idx_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_wr) begin
            state_q   <= ST_PROG;
            wr_addr_q <= addr;
            wr_byte_q <= rd_byte & data_i;  // cells only clear
          end else if (start_lk) begin
            state_q <= ST_LOCK;
            lsel_q  <= (op_i == OP_LOCK2);
          end else if (start_er) begin
            state_q  <= ST_ERASE;
            er_idx_q <= '0;
            lock1_q  <= 1'b0;
            lock2_q  <= 1'b0;
          end
        end
        ST_PROG: if (tmr_done) state_q <= ST_IDLE;
        ST_LOCK: begin
          if (tmr_done) begin
            state_q <= ST_IDLE;
            if (lsel_q) lock2_q <= 1'b1;
            else        lock1_q <= 1'b1;
          end
        end
        ST_ERASE: begin
          er_idx_q <= er_idx_q + ADDR_W'(1);
          if (er_idx_q == LAST) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign arr_we    = ((state_q == ST_PROG) & tmr_done) | (state_q == ST_ERASE);
  assign arr_waddr = (state_q == ST_ERASE) ? er_idx_q : wr_addr_q;
  assign arr_wdata = (state_q == ST_ERASE) ? BLANK : wr_byte_q;

  pgm_array #(.AW(ADDR_W)) u_arr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (arr_we),
    .waddr_i (arr_waddr),
    .wdata_i (arr_wdata),
    .raddr_i (addr),
    .rdata_o (rd_byte)
  );

  assign rd_ok     = (op_i == OP_READ) & ~(lock1_q & lock2_q);
  assign data_oe_o = rst_pin_i & ~hv_i & (rd_ok | (op_i == OP_IDENT));
  assign poll      = (state_q == ST_PROG) & (addr == wr_addr_q);

  always_comb begin
    data_o = 8'h00;
    if (data_oe_o) begin
      if (op_i == OP_IDENT) begin
        if (addr == ADDR_W'(0))      data_o = IDENT_B0;
        else if (addr == ADDR_W'(1)) data_o = IDENT_B1;
      end else if (poll) begin
        data_o = {~wr_byte_q[7], wr_byte_q[6:0]};
      end else begin
        data_o = rd_byte;
      end
    end
  end

  assign rdy_o = idle;
endmodule

// File: rtl/pgm_port_ctrl_chk.sv
module pgm_port_ctrl_chk #(
  parameter int AW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hv_i,
  input logic          rst_pin_i,
  input logic          pgm_n_i,
  input logic          step_i,
  input logic [3:0]    op_i,
  input logic          data_oe_o,
  input logic          rdy_o,
  input logic [AW-1:0] addr_i,
  input logic          lock1_i,
  input logic          lock2_i
);
  logic pgm_p, step_p, rstp_p;
  logic pgm_rise, step_rise, rstp_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pgm_p  <= 1'b1;
      step_p <= 1'b0;
      rstp_p <= 1'b0;
    end else begin
      pgm_p  <= pgm_n_i;
      step_p <= step_i;
      rstp_p <= rst_pin_i;
    end
  end

  assign pgm_rise  = pgm_n_i & ~pgm_p;
  assign step_rise = step_i & ~step_p;
  assign rstp_rise = rst_pin_i & ~rstp_p;

  a_r1_addr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rstp_rise |=> (addr_i == '0));

  a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && step_rise && !rstp_rise) |=> (addr_i == $past(addr_i) + AW'(1)));

  a_r11_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_o && !rstp_rise) |=> $stable(addr_i));

  a_r4_lock_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && pgm_rise && hv_i && (op_i == 4'h3 || op_i == 4'h4)) |=> !rdy_o);

  a_r12_undef_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && pgm_rise && (op_i == 4'h0 || op_i > 4'h6)) |=> rdy_o);

  a_r6_lock_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(lock1_i) || $fell(lock2_i)) |-> !rdy_o);

  a_r10_oe_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (rst_pin_i && !hv_i));
endmodule

bind pgm_port_ctrl pgm_port_ctrl_chk #(.AW(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hv_i      (hv_i),
  .rst_pin_i (rst_pin_i),
  .pgm_n_i   (pgm_n_i),
  .step_i    (step_i),
  .op_i      (op_i),
  .data_oe_o (data_oe_o),
  .rdy_o     (rdy_o),
  .addr_i    (addr),
  .lock1_i   (lock1_q),
  .lock2_i   (lock2_q)
);

// File: tb/pgm_port_ctrl_test.sv
module pgm_port_ctrl_test;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;
  localparam int WR    = 5;
  localparam int EH    = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hv = 1'b0, rst_pin = 1'b1, pgm_n = 1'b1, step = 1'b0;
  logic [3:0] op = 4'h0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       oe, rdy;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pgm_port_ctrl #(.ADDR_W(AW), .WR_CYC(WR), .ERASE_HOLD(EH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .hv_i(hv), .rst_pin_i(rst_pin),
    .pgm_n_i(pgm_n), .step_i(step), .op_i(op), .data_i(din),
    .data_o(dout), .data_oe_o(oe), .rdy_o(rdy)
  );

  // reference model
  logic [7:0] m_mem [DEPTH];
  int   m_addr, m_waddr, m_eidx, m_cnt, m_hold, m_st;
  logic [7:0] m_wbyte;
  bit   m_l1, m_l2, m_lsel, m_pq, m_sq, m_rq;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
      m_addr = 0; m_waddr = 0; m_eidx = 0; m_cnt = 0; m_hold = 0; m_st = 0;
      m_wbyte = 0; m_l1 = 0; m_l2 = 0; m_lsel = 0;
      m_pq = 1; m_sq = 0; m_rq = 0;
    end else begin
      bit pr, sr, rr, idl;
      int old_addr, old_hold;
      pr = pgm_n && !m_pq; sr = step && !m_sq; rr = rst_pin && !m_rq;
      idl = (m_st == 0); old_addr = m_addr; old_hold = m_hold;
      if (m_st == 1) begin
        m_cnt--;
        if (m_cnt == 0) begin m_mem[m_waddr] = m_wbyte; m_st = 0; end
      end else if (m_st == 2) begin
        m_cnt--;
        if (m_cnt == 0) begin
          if (m_lsel) m_l2 = 1; else m_l1 = 1;
          m_st = 0;
        end
      end else if (m_st == 3) begin
        m_mem[m_eidx] = 8'hFF;
        m_eidx++;
        if (m_eidx == DEPTH) m_st = 0;
      end
      if (idl && pr && hv) begin
        if (op == 4'h2 && !m_l1) begin
          m_waddr = old_addr; m_wbyte = m_mem[old_addr] & din; m_st = 1; m_cnt = WR;
        end else if (op == 4'h3 || op == 4'h4) begin
          m_st = 2; m_cnt = WR; m_lsel = (op == 4'h4);
        end else if (op == 4'h5 && old_hold >= EH) begin
          m_st = 3; m_eidx = 0; m_l1 = 0; m_l2 = 0;
        end
      end
      if (!pgm_n && hv && op == 4'h5) m_hold = (m_hold < EH) ? m_hold + 1 : EH;
      else m_hold = 0;
      if (rr) m_addr = 0;
      else if (sr && idl) m_addr = (m_addr + 1) % DEPTH;
      m_pq = pgm_n; m_sq = step; m_rq = rst_pin;
    end
  end

  function automatic bit exp_oe();
    return rst_pin && !hv && ((op == 4'h1 && !(m_l1 && m_l2)) || op == 4'h6);
  endfunction

  function automatic logic [7:0] exp_data();
    if (!exp_oe()) return 8'h00;
    if (op == 4'h6) return (m_addr == 0) ? 8'h1E : (m_addr == 1) ? 8'h41 : 8'h00;
    if (m_st == 1 && m_addr == m_waddr) return {~m_wbyte[7], m_wbyte[6:0]};
    return m_mem[m_addr];
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 rdy vs model", rdy, (m_st == 0));
      chk("R10 oe vs model", oe, exp_oe());
      chk("R3 data vs model", dout, exp_data());
    end
  end

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic strobe();
    pgm_n = 1'b0; cyc(); pgm_n = 1'b1; cyc();
  endtask

  task automatic step_pulse();
    step = 1'b1; cyc(); step = 1'b0; cyc();
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!rdy && n < 100) begin n++; cyc(); end
  endtask

  task automatic rd(input logic [3:0] o);
    hv = 1'b0; op = o; #1;
  endtask

  initial begin
    int n;
    repeat (3) cyc();
    rst_n = 1'b1; cyc();
    chk("R13 ready after reset", rdy, 1);
    rd(4'h1);
    chk("R13 blank byte", dout, 8'hFF);

    // R10 / R1: reset pin low disables output, rising edge clears address
    step_pulse();
    rst_pin = 1'b0; #1;
    chk("R10 oe low with reset pin low", oe, 0);
    chk("R10 data zero when disabled", dout, 8'h00);
    cyc(); rst_pin = 1'b1; cyc();
    op = 4'h6; #1;
    chk("R1 address cleared", dout, 8'h1E);

    // R3/R4/R5: byte write with polling
    hv = 1'b1; op = 4'h2; din = 8'hA5; strobe();
    chk("R4 busy after strobe", rdy, 0);
    rd(4'h1);
    chk("R5 polling bit7 inverted", dout, 8'h25);
    wait_rdy(n);
    chk("R4 busy length", n, WR);
    chk("R3 written byte", dout, 8'hA5);
    hv = 1'b1; op = 4'h2; din = 8'h0F; strobe(); wait_rdy(n);
    rd(4'h1);
    chk("R3 bits only clear", dout, 8'h05);

    // R11: step during busy ignored
    step_pulse();
    hv = 1'b1; op = 4'h2; din = 8'h3C; strobe();
    step_pulse();
    hv = 1'b0; op = 4'h2; pgm_n = 1'b0; cyc(); pgm_n = 1'b1; cyc();
    wait_rdy(n);
    rd(4'h1);
    chk("R11 step and strobe ignored while busy", dout, 8'h3C);

    // R2: wrap from last address to 0
    for (int i = 0; i < DEPTH - 1; i++) step_pulse();
    chk("R2 wrap to address 0", dout, 8'h05);

    // R12: undefined op starts nothing
    hv = 1'b1; op = 4'h7; din = 8'h00; strobe();
    chk("R12 undefined op stays ready", rdy, 1);
    op = 4'h0; strobe();
    chk("R12 op 0 stays ready", rdy, 1);
    rd(4'h1);
    chk("R12 data unchanged", dout, 8'h05);

    // R9 identification
    rd(4'h6);
    chk("R9 ident byte 0", dout, 8'h1E);
    step_pulse();
    chk("R9 ident byte 1", dout, 8'h41);
    step_pulse();
    chk("R9 ident other address", dout, 8'h00);
    rst_pin = 1'b0; cyc(); rst_pin = 1'b1; cyc();

    // R10: high voltage disables output
    op = 4'h1; hv = 1'b1; #1;
    chk("R10 oe low with hv", oe, 0);

    // R7: lock bit 1 blocks writes
    op = 4'h3; strobe();
    chk("R7 lock write busy", rdy, 0);
    wait_rdy(n);
    chk("R7 lock write length", n, WR);
    op = 4'h2; din = 8'h00; strobe();
    chk("R7 blocked write no busy", rdy, 1);
    rd(4'h1);
    chk("R7 data unchanged", dout, 8'h05);
    chk("R8 read allowed with lock1 only", oe, 1);

    // R8: both locks block read
    hv = 1'b1; op = 4'h4; strobe(); wait_rdy(n);
    rd(4'h1);
    chk("R8 read blocked", oe, 0);
    rd(4'h6);
    chk("R9 ident with locks", dout, 8'h1E);

    // R6: short hold does nothing
    hv = 1'b1; op = 4'h5; pgm_n = 1'b0;
    repeat (EH - 3) cyc();
    pgm_n = 1'b1; cyc();
    chk("R6 short hold no erase", rdy, 1);
    rd(4'h1);
    chk("R6 locks kept after short hold", oe, 0);

    // R6: full erase
    hv = 1'b1; op = 4'h5; pgm_n = 1'b0;
    repeat (EH + 2) cyc();
    pgm_n = 1'b1; cyc();
    wait_rdy(n);
    chk("R6 erase busy length", n, DEPTH);
    rd(4'h1);
    chk("R6 locks cleared", oe, 1);
    chk("R6 byte 0 blank", dout, 8'hFF);
    step_pulse();
    chk("R6 byte 1 blank", dout, 8'hFF);

    cyc();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule